// File: doc/BRIEF.md
# I2C Register Target for Regulator Control

This block is the serial control port of a voltage regulator controller. It listens on an I2C bus through oversampled SCL and SDA lines and holds six byte-wide registers. Two of them set the output level for the two selectable operating points. One holds the control fields. Two hold fixed identification codes. The last reports live status. The register fields leave the block as plain parallel outputs. The block drives SDA only through an open-drain enable, and only to acknowledge a byte or to return read data.

A host writes one register per transaction: START, address byte with write, register index, data, STOP. To read, the host first writes the register index and then sends a repeated START, the address byte with read, and takes one data byte before STOP. The block never acknowledges a high-speed master code. It flags high-speed operation until the next STOP.

The byte engine is a single state machine with these states:
- ST_IDLE waits for START.
- ST_ADDR shifts in the address byte.
- ST_ACK_WADDR and ST_ACK_RADDR acknowledge a matching address for a write or a read.
- ST_REG takes the register index, and ST_ACK_REG acknowledges it.
- ST_WDATA takes the data byte, and ST_ACK_DATA acknowledges it; the register write happens on entry to ST_ACK_DATA.
- ST_RDATA shifts out the read byte.
- ST_MACK lets the host answer the read byte.
- ST_SKIP stays silent until the next START or STOP.

Transitions follow the order of a byte:
- A byte is complete on the eighth SCL rise. The state changes on the SCL fall that follows it.
- From ST_ADDR the machine goes to ST_SKIP on a high-speed code or a foreign address. Otherwise it goes to an acknowledge state.
- Each acknowledge state moves on at the next SCL fall: ST_ACK_WADDR to ST_REG, ST_ACK_REG to ST_WDATA, ST_ACK_DATA to ST_SKIP, and ST_ACK_RADDR to ST_RDATA.
- ST_RDATA moves to ST_MACK after eight falls, and ST_MACK moves to ST_SKIP.
- START from any state goes to ST_ADDR, and STOP from any state goes to ST_IDLE.

Top module: `regctl_i2c_target`

## Requirements
- R1: After reset, vsel0_o = 0xD4, vsel1_o = 0xCD and ctrl_o = 0x80. Register 3 reads 0x85 and register 4 reads 0x00.
- R2: An address byte whose upper seven bits are 0x60 is acknowledged (SDA driven low on the ninth clock). Any other address gets no acknowledge, and the rest of that transaction has no effect on any register.
- R3: A write to register 0 or 1 stores the data byte. The new value appears on vsel0_o or vsel1_o while SCL is low at the start of the data acknowledge.
- R4: A read (index write, repeated START, address with bit 0 = 1) returns the indexed register MSB first on SDA.
- R5: Writes to registers 3, 4, 5 and to any index above 5 are acknowledged but discarded. A read of any index above 5 returns 0x00.
- R6: Bits 3 and 2 of register 2 (ctrl_o) always read as 0. The other bits of register 2 store what is written.
- R7: Writing register 2 with bit 2 = 1 returns registers 0 to 2 to their reset values and sets register 5 bit 2.
- R8: Register 5 reads as {stat_i[6:2], flag, stat_i[1:0]}, where flag is the register-reset flag and stat_i is sampled as the read byte begins. The flag clears after register 5 has been read.
- R9: A byte 00001xxx after START is not acknowledged. hs_mode_o is 1 from that byte until STOP, and it falls only while SCL is high.
- R10: sda_oe_o changes only while SCL is low, and it is 0 outside acknowledge and read-data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| stat_i | input | 7 | Live status bits for register 5 (all bits except bit 2) |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| hs_mode_o | output | 1 | High-speed code seen, held until STOP |
| vsel0_o | output | 8 | Register 0, setting for the low select state |
| vsel1_o | output | 8 | Register 1, setting for the high select state |
| ctrl_o | output | 8 | Register 2, control fields |

## Verification
The bench builds the block with its default parameters: target address 0x60, two synchroniser stages, and the stated reset and identification values. It runs SCL at ten system clocks per half period. That gives the three-cycle synchroniser and edge-detect path room to act inside each SCL phase, and lets the bench sample acknowledge and read-data bits in the middle of the SCL high time. With these values it can walk every register index, including one out of range, and a soft reset followed by the flag clearing on read. It also covers a foreign address and a high-speed code followed by a normal write.

// File: rtl/regctl_pkg.sv
package regctl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hF3;
    localparam int CTRL_RST_BIT = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WADDR,
        ST_REG,
        ST_ACK_REG,
        ST_WDATA,
        ST_ACK_DATA,
        ST_ACK_RADDR,
        ST_RDATA,
        ST_MACK,
        ST_SKIP
    } tgt_state_t;
endpackage

// File: rtl/regctl_i2c_sync.sv
module regctl_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/regctl_i2c_fsm.sv
module regctl_i2c_fsm
    import regctl_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              hs_mode,
    output logic              wr_en,
    output logic              rd_take,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] reg_ptr
);
    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              got8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            got8    <= 1'b0;
            hs_mode <= 1'b0;
            reg_ptr <= '0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            got8    <= 1'b0;
            hs_mode <= 1'b0;
        end else if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
            got8  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W-1)) got8 <= 1'b1;
                    end else if (scl_fall && got8) begin
                        got8 <= 1'b0;
                        cnt  <= '0;
                        if (state == ST_ADDR) begin
                            if (sh[7:3] == 5'b00001) begin
                                hs_mode <= 1'b1;
                                state   <= ST_SKIP;
                            end else if (sh[7:1] == TARGET_ADDR) begin
                                state <= sh[0] ? ST_ACK_RADDR : ST_ACK_WADDR;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_REG) begin
                            reg_ptr <= sh;
                            state   <= ST_ACK_REG;
                        end else begin
                            state <= ST_ACK_DATA;
                        end
                    end
                end
                ST_ACK_WADDR: if (scl_fall) state <= ST_REG;
                ST_ACK_REG:   if (scl_fall) state <= ST_WDATA;
                ST_ACK_DATA:  if (scl_fall) state <= ST_SKIP;
                ST_ACK_RADDR: begin
                    if (scl_fall) begin
                        sh    <= rd_data;
                        cnt   <= '0;
                        state <= ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W-1)) begin
                            state <= ST_MACK;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: if (scl_fall) state <= ST_SKIP;
                ST_IDLE, ST_SKIP: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        rd_take = 1'b0;
        wr_data = sh;
        unique case (state)
            ST_ACK_WADDR, ST_ACK_RADDR, ST_ACK_REG, ST_ACK_DATA: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~sh[BYTE_W-1];
            default: sda_oe = 1'b0;
        endcase
        if (state == ST_WDATA && scl_fall && got8 && !start_det && !stop_det)
            wr_en = 1'b1;
        if (state == ST_ACK_RADDR && scl_fall && !start_det && !stop_det)
            rd_take = 1'b1;
    end
endmodule

// File: rtl/regctl_regs.sv
module regctl_regs
    import regctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEF_R0 = 8'hD4,
    parameter logic [BYTE_W-1:0] DEF_R1 = 8'hCD,
    parameter logic [BYTE_W-1:0] DEF_R2 = 8'h80,
    parameter logic [BYTE_W-1:0] ID_R3  = 8'h85,
    parameter logic [BYTE_W-1:0] ID_R4  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_take,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] reg_ptr,
    input  logic [6:0]        stat_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] r0,
    output logic [BYTE_W-1:0] r1,
    output logic [BYTE_W-1:0] r2
);
    localparam logic [BYTE_W-1:0] DEF_R2_M = DEF_R2 & CTRL_KEEP;
    logic rst_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r0       <= DEF_R0;
            r1       <= DEF_R1;
            r2       <= DEF_R2_M;
            rst_flag <= 1'b0;
        end else if (wr_en) begin
            case (reg_ptr)
                8'd0: r0 <= wr_data;
                8'd1: r1 <= wr_data;
                8'd2: begin
                    if (wr_data[CTRL_RST_BIT]) begin
                        r0       <= DEF_R0;
                        r1       <= DEF_R1;
                        r2       <= DEF_R2_M;
                        rst_flag <= 1'b1;
                    end else begin
                        r2 <= wr_data & CTRL_KEEP;
                    end
                end
                default: ;
            endcase
        end else if (rd_take && reg_ptr == 8'd5) begin
            rst_flag <= 1'b0;
        end
    end

    always_comb begin
        case (reg_ptr)
            8'd0:    rd_data = r0;
            8'd1:    rd_data = r1;
            8'd2:    rd_data = r2;
            8'd3:    rd_data = ID_R3;
            8'd4:    rd_data = ID_R4;
            8'd5:    rd_data = {stat_i[6:2], rst_flag, stat_i[1:0]};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/regctl_i2c_target.sv
module regctl_i2c_target
    import regctl_pkg::*;
#(
    parameter logic [6:0]        TARGET_ADDR = 7'h60,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] DEF_R0      = 8'hD4,
    parameter logic [BYTE_W-1:0] DEF_R1      = 8'hCD,
    parameter logic [BYTE_W-1:0] DEF_R2      = 8'h80,
    parameter logic [BYTE_W-1:0] ID_R3       = 8'h85,
    parameter logic [BYTE_W-1:0] ID_R4       = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [6:0]        stat_i,
    output logic              sda_oe_o,
    output logic              hs_mode_o,
    output logic [BYTE_W-1:0] vsel0_o,
    output logic [BYTE_W-1:0] vsel1_o,
    output logic [BYTE_W-1:0] ctrl_o
);
    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en, rd_take;
    logic [BYTE_W-1:0] wr_data, reg_ptr, rd_data;

    regctl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    regctl_i2c_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe_o), .hs_mode(hs_mode_o),
        .wr_en(wr_en), .rd_take(rd_take), .wr_data(wr_data), .reg_ptr(reg_ptr)
    );

    regctl_regs #(
        .DEF_R0(DEF_R0), .DEF_R1(DEF_R1), .DEF_R2(DEF_R2),
        .ID_R3(ID_R3), .ID_R4(ID_R4)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_take(rd_take),
        .wr_data(wr_data), .reg_ptr(reg_ptr), .stat_i(stat_i),
        .rd_data(rd_data), .r0(vsel0_o), .r1(vsel1_o), .r2(ctrl_o)
    );
endmodule

// File: rtl/regctl_i2c_target_chk.sv
module regctl_i2c_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       hs_mode_o,
    input logic [7:0] vsel0_o,
    input logic [7:0] vsel1_o,
    input logic [7:0] ctrl_o
);
    // R10: the data line drive only moves during SCL low
    a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R3: register outputs update only during SCL low
    a_r3_vsel0_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsel0_o) |-> !scl_i);
    a_r3_vsel1_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsel1_o) |-> !scl_i);

    // R6: reserved and self-clearing control bits stay zero
    a_r6_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[3:2] == 2'b00);

    // R9: high-speed code is never acknowledged
    a_r9_hs_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode_o) |-> !sda_oe_o);

    // R9: high-speed flag ends only at STOP, with SCL high
    a_r9_hs_ends_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode_o) |-> scl_i);
endmodule

bind regctl_i2c_target regctl_i2c_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .hs_mode_o(hs_mode_o), .vsel0_o(vsel0_o), .vsel1_o(vsel1_o), .ctrl_o(ctrl_o)
);

// File: tb/tb_regctl_i2c_target.sv
module tb_regctl_i2c_target;
    localparam logic [6:0] TADDR = 7'h60;
    localparam int NVEC = 18;
    // {is_read, reg index, write data, expected read data}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'h00, 8'hD4},
        {1'b1, 8'h01, 8'h00, 8'hCD},
        {1'b1, 8'h02, 8'h00, 8'h80},
        {1'b1, 8'h03, 8'h00, 8'h85},
        {1'b1, 8'h04, 8'h00, 8'h00},
        {1'b1, 8'h05, 8'h00, 8'hA3},
        {1'b0, 8'h00, 8'h55, 8'h00},
        {1'b1, 8'h00, 8'h00, 8'h55},
        {1'b0, 8'h01, 8'h3C, 8'h00},
        {1'b1, 8'h01, 8'h00, 8'h3C},
        {1'b0, 8'h02, 8'hFB, 8'h00},
        {1'b1, 8'h02, 8'h00, 8'hF3},
        {1'b0, 8'h03, 8'h11, 8'h00},
        {1'b1, 8'h03, 8'h00, 8'h85},
        {1'b0, 8'h09, 8'h77, 8'h00},
        {1'b1, 8'h09, 8'h00, 8'h00},
        {1'b0, 8'h05, 8'hFF, 8'h00},
        {1'b1, 8'h05, 8'h00, 8'hA3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic [6:0] stat = 7'h53;
    logic sda_oe, hs_mode;
    logic [7:0] vsel0, vsel1, ctrl;
    wire sda_line = m_sda & ~sda_oe;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regctl_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .stat_i(stat),
        .sda_oe_o(sda_oe), .hs_mode_o(hs_mode),
        .vsel0_o(vsel0), .vsel1_o(vsel1), .ctrl_o(ctrl)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        wclk(4); m_sda = b; wclk(6); scl = 1'b1; wclk(10); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wclk(4); m_sda = 1'b1; wclk(6); scl = 1'b1; wclk(5); b = sda_line; wclk(5); scl = 1'b0;
    endtask

    task automatic byte_out(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(nack);
    endtask

    task automatic byte_in(output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(1'b1);
    endtask

    task automatic bus_start();
        wclk(10); m_sda = 1'b0; wclk(10); scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wclk(4); m_sda = 1'b1; wclk(6); scl = 1'b1; wclk(10); m_sda = 1'b0; wclk(10); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(4); m_sda = 1'b0; wclk(6); scl = 1'b1; wclk(10); m_sda = 1'b1; wclk(10);
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, output logic [2:0] nacks);
        bus_start();
        byte_out({TADDR, 1'b0}, nacks[2]);
        byte_out(idx, nacks[1]);
        byte_out(d, nacks[0]);
        bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d, output logic [2:0] nacks);
        bus_start();
        byte_out({TADDR, 1'b0}, nacks[2]);
        byte_out(idx, nacks[1]);
        bus_rstart();
        byte_out({TADDR, 1'b1}, nacks[0]);
        byte_in(d);
        bus_stop();
    endtask

    function automatic string vec_req(input int i);
        if (i < 5) return "R1";
        if (i == 5 || i >= 16) return "R8";
        if (i < 10) return "R4";
        if (i < 12) return "R6";
        return "R5";
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        logic [2:0] nk;
        logic [7:0] rd;
        logic a;
        wclk(5);
        check("R1 vsel0 reset", vsel0, 8'hD4);
        check("R1 vsel1 reset", vsel1, 8'hCD);
        check("R1 ctrl reset", ctrl, 8'h80);
        check("R10 oe idle in reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        wclk(5);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][24]) begin
                reg_read(VEC[i][23:16], rd, nk);
                check({vec_req(i), " R4 read data"}, rd, VEC[i][7:0]);
                check("R2 read acks", {5'd0, nk}, 8'h00);
            end else begin
                reg_write(VEC[i][23:16], VEC[i][15:8], nk);
                check({vec_req(i), " R5 write acks"}, {5'd0, nk}, 8'h00);
            end
        end

        check("R3 vsel0 port", vsel0, 8'h55);
        check("R3 vsel1 port", vsel1, 8'h3C);
        check("R6 ctrl port", ctrl, 8'hF3);

        // R7 soft reset
        reg_write(8'h02, 8'h04, nk);
        check("R7 reset write acks", {5'd0, nk}, 8'h00);
        check("R7 vsel0 default", vsel0, 8'hD4);
        check("R7 vsel1 default", vsel1, 8'hCD);
        check("R7 ctrl default", ctrl, 8'h80);
        reg_read(8'h05, rd, nk);
        check("R7 flag set in reg5", rd, 8'hA7);
        reg_read(8'h05, rd, nk);
        check("R8 flag cleared after read", rd, 8'hA3);
        stat = 7'h2E;
        reg_read(8'h05, rd, nk);
        check("R8 live status", rd, 8'h5A);
        reg_read(8'h02, rd, nk);
        check("R7 reg2 reads default", rd, 8'h80);

        // R2 foreign address
        bus_start();
        byte_out({7'h61, 1'b0}, a);
        check("R2 foreign addr nack", {7'd0, a}, 8'h01);
        byte_out(8'h00, a);
        check("R2 silent after foreign addr", {7'd0, a}, 8'h01);
        byte_out(8'h11, a);
        bus_stop();
        check("R2 no write from foreign addr", vsel0, 8'hD4);

        // R9 high-speed master code
        bus_start();
        byte_out(8'h0A, a);
        check("R9 hs code nack", {7'd0, a}, 8'h01);
        wclk(5);
        check("R9 hs flag set", {7'd0, hs_mode}, 8'h01);
        bus_stop();
        check("R9 hs flag cleared at stop", {7'd0, hs_mode}, 8'h00);
        reg_write(8'h00, 8'h77, nk);
        check("R9 normal write after hs acks", {5'd0, nk}, 8'h00);
        check("R9 normal write after hs data", vsel0, 8'h77);
        check("R10 oe released after stop", {7'd0, sda_oe}, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule